// File: doc/BRIEF.md
# Windowed Exposure Statistics Accumulator

This block gathers luminance statistics for automatic exposure control. A rectangular measurement window is set per field. Horizontal and vertical enable bits choose, for each axis, between the programmed window and the full image extent. The window is split into an 8 by 8 grid of equal blocks. During the field every accepted pixel is added into the running sum of its block. When the last pixel of the bottom-right block arrives, a sequential divider turns each sum into an 8-bit average. The largest and smallest of the 64 averages are tracked as the divider produces them.

Results are held in a shadow bank. They move into the readable bank only at the next field start, so a reader never sees a mix of two fields. A control processor reads the averages and the two extremes by placing an address on a 7-bit bus. Data comes back combinationally on an 8-bit bus in the same cycle.

Top module: `exp_stats_top`

## Requirements
- R1: After reset every readable address returns 0.
- R2: The window is divided into 8 columns of width floor(W/8) and 8 rows of height floor(H/8), where W and H are the window extents in pixels and lines. Pixels to the right of column 7 or below row 7 are not counted.
- R3: Each block result is floor(block sum / (block width × block height)), 8 bits wide.
- R4: Block results sit at addresses 00h–3Fh. The address is column×8 + row: column counts from the left, row counts from the top, and each group of eight consecutive addresses is one column read top to bottom.
- R5: Address 60h returns the largest of the 64 block results and address 61h returns the smallest, so 60h ≥ 61h.
- R6: Addresses 40h–5Fh and 62h–7Fh return 0.
- R7: With the horizontal enable low, the horizontal span is pixel 0 to IMG_W−1 and the start/end inputs are ignored. The vertical enable works the same way with lines 0 to IMG_H−1.
- R8: The readable results change only on a field-start pulse. They change only if the previous field's window completed and all 64 divisions finished before that pulse. A field start that arrives during the computation abandons it and leaves the old results in place.
- R9: Window inputs are sampled at the field-start pulse. A field whose block width or block height is 0 produces no update.
- R10: Read data follows the read address combinationally, within the same cycle.
- R11: A pixel is counted only in a cycle with the pixel strobe high. The pixel position counts strobed pixels since the last line or field start. The line number counts line strobes since the field start.
- R12: Block sums restart at every field start, so each published set reflects one field only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | One-cycle pulse opening a field (line 0) |
| line_strobe | input | 1 | One-cycle pulse opening the next line |
| pix_valid | input | 1 | Pixel strobe |
| pix_luma | input | LUMA_W | Pixel luminance |
| win_h_start | input | HW | First pixel of window |
| win_h_end | input | HW | Last pixel of window |
| win_v_start | input | VW | First line of window |
| win_v_end | input | VW | Last line of window |
| win_h_en | input | 1 | 1: use horizontal window, 0: full width |
| win_v_en | input | 1 | 1: use vertical window, 0: full height |
| rd_addr | input | 7 | Result address |
| rd_data | output | LUMA_W | Result data |

## Verification
The assertions watch several properties on every cycle. Unused addresses must read zero. Pixel acceptance must never occur without the strobe. The sums must be clear right after each field start. The readable extremes must hold between field starts, and a publication must leave the maximum no lower than the minimum. The block averages themselves can only be judged by the bench. Its scenarios fill complete fields with known patterns and compare all 66 results, covering these cases:
- non-power-of-two block sizes with leftover pixels;
- axes with the enable off;
- windows too small to form a block;
- a computation abandoned by an early field start.

// File: rtl/exp_stats_pkg.sv
package exp_stats_pkg;
    localparam logic [6:0] ADDR_MAX = 7'h60;
    localparam logic [6:0] ADDR_MIN = 7'h61;
    typedef enum logic [0:0] {PH_IDLE, PH_DIV} phase_e;
endpackage

// File: rtl/exp_win_track.sv
module exp_win_track #(
    parameter int HW      = 10,
    parameter int VW      = 9,
    parameter int IMG_W   = 720,
    parameter int IMG_H   = 240,
    parameter int GRID_LG = 3,
    localparam int BW_W   = HW + 1 - GRID_LG,
    localparam int BH_W   = VW + 1 - GRID_LG,
    localparam int CNT_W  = BW_W + BH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   field_start,
    input  logic                   line_strobe,
    input  logic                   pix_valid,
    input  logic [HW-1:0]          h_start,
    input  logic [HW-1:0]          h_end,
    input  logic [VW-1:0]          v_start,
    input  logic [VW-1:0]          v_end,
    input  logic                   h_en,
    input  logic                   v_en,
    output logic                   acc_en,
    output logic [2*GRID_LG-1:0]   blk_addr,
    output logic                   last_pix,
    output logic [CNT_W-1:0]       blk_pixels
);
    localparam int GRID = 1 << GRID_LG;

    typedef struct packed {
        logic [HW-1:0]     hcnt;
        logic [VW-1:0]     vcnt;
        logic [HW-1:0]     x0;
        logic [VW-1:0]     y0;
        logic [BW_W-1:0]   bw;
        logic [BH_W-1:0]   bh;
        logic [BW_W-1:0]   hsub;
        logic [BH_W-1:0]   vsub;
        logic [GRID_LG:0]  col;
        logic [GRID_LG:0]  row;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [HW-1:0] x0_n, x1_n;
    logic [VW-1:0] y0_n, y1_n;
    logic [HW:0]   wid_n;
    logic [VW:0]   hgt_n;
    logic          sizes_ok, in_h, in_v;

    always_comb begin
        x0_n  = h_en ? h_start : '0;
        x1_n  = h_en ? h_end   : HW'(IMG_W - 1);
        y0_n  = v_en ? v_start : '0;
        y1_n  = v_en ? v_end   : VW'(IMG_H - 1);
        wid_n = (x1_n >= x0_n) ? ({1'b0, x1_n} - {1'b0, x0_n} + (HW+1)'(1)) : '0;
        hgt_n = (y1_n >= y0_n) ? ({1'b0, y1_n} - {1'b0, y0_n} + (VW+1)'(1)) : '0;

        sizes_ok = (trk_q.bw != '0) && (trk_q.bh != '0);
        in_h     = (trk_q.hcnt >= trk_q.x0) && !trk_q.col[GRID_LG];
        in_v     = (trk_q.vcnt >= trk_q.y0) && !trk_q.row[GRID_LG];
        acc_en   = pix_valid && in_h && in_v && sizes_ok;
        last_pix = acc_en && (trk_q.col == (GRID_LG+1)'(GRID - 1))
                          && (trk_q.row == (GRID_LG+1)'(GRID - 1))
                          && (trk_q.hsub == trk_q.bw - BW_W'(1))
                          && (trk_q.vsub == trk_q.bh - BH_W'(1));
        blk_addr   = {trk_q.col[GRID_LG-1:0], trk_q.row[GRID_LG-1:0]};
        blk_pixels = CNT_W'(trk_q.bw) * CNT_W'(trk_q.bh);

        trk_d = trk_q;
        if (field_start) begin
            trk_d.x0   = x0_n;
            trk_d.y0   = y0_n;
            trk_d.bw   = wid_n[HW:GRID_LG];
            trk_d.bh   = hgt_n[VW:GRID_LG];
            trk_d.hcnt = '0;
            trk_d.vcnt = '0;
            trk_d.hsub = '0;
            trk_d.vsub = '0;
            trk_d.col  = '0;
            trk_d.row  = '0;
        end else if (line_strobe) begin
            trk_d.hcnt = '0;
            trk_d.hsub = '0;
            trk_d.col  = '0;
            trk_d.vcnt = trk_q.vcnt + VW'(1);
            if (in_v && sizes_ok) begin
                if (trk_q.vsub == trk_q.bh - BH_W'(1)) begin
                    trk_d.vsub = '0;
                    trk_d.row  = trk_q.row + (GRID_LG+1)'(1);
                end else begin
                    trk_d.vsub = trk_q.vsub + BH_W'(1);
                end
            end
        end else if (pix_valid) begin
            trk_d.hcnt = trk_q.hcnt + HW'(1);
            if (in_h && sizes_ok) begin
                if (trk_q.hsub == trk_q.bw - BW_W'(1)) begin
                    trk_d.hsub = '0;
                    trk_d.col  = trk_q.col + (GRID_LG+1)'(1);
                end else begin
                    trk_d.hsub = trk_q.hsub + BW_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/exp_avg_div.sv
module exp_avg_div #(
    parameter int SUM_W = 23,
    parameter int CNT_W = 15,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SUM_W-1:0] dividend,
    input  logic [CNT_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    localparam int STEP_W = $clog2(SUM_W + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  rem;
        logic [SUM_W-1:0]  dvd;
        logic [Q_W-1:0]    quo;
    } div_t;

    div_t div_d, div_q;
    logic [CNT_W:0] trial;
    logic           fits;

    always_comb begin
        trial = {div_q.rem, div_q.dvd[SUM_W-1]};
        fits  = trial >= {1'b0, divisor};
        div_d = div_q;
        div_d.done = 1'b0;
        if (start && !div_q.busy) begin
            div_d.busy = 1'b1;
            div_d.step = '0;
            div_d.rem  = '0;
            div_d.dvd  = dividend;
            div_d.quo  = '0;
        end else if (div_q.busy) begin
            div_d.rem  = fits ? CNT_W'(trial - {1'b0, divisor}) : CNT_W'(trial);
            div_d.dvd  = {div_q.dvd[SUM_W-2:0], 1'b0};
            div_d.quo  = {div_q.quo[Q_W-2:0], fits};
            div_d.step = div_q.step + STEP_W'(1);
            if (div_q.step == STEP_W'(SUM_W - 1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
        busy     = div_q.busy;
        done     = div_q.done;
        quotient = div_q.quo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/exp_stats_top.sv
module exp_stats_top
    import exp_stats_pkg::*;
#(
    parameter int LUMA_W = 8,
    parameter int HW     = 10,
    parameter int VW     = 9,
    parameter int IMG_W  = 720,
    parameter int IMG_H  = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_strobe,
    input  logic              pix_valid,
    input  logic [LUMA_W-1:0] pix_luma,
    input  logic [HW-1:0]     win_h_start,
    input  logic [HW-1:0]     win_h_end,
    input  logic [VW-1:0]     win_v_start,
    input  logic [VW-1:0]     win_v_end,
    input  logic              win_h_en,
    input  logic              win_v_en,
    input  logic [6:0]        rd_addr,
    output logic [LUMA_W-1:0] rd_data
);
    localparam int GRID_LG = 3;
    localparam int BLK_AW  = 2 * GRID_LG;
    localparam int NBLK    = 1 << BLK_AW;
    localparam int CNT_W   = HW + VW + 2 - 2 * GRID_LG;
    localparam int SUM_W   = LUMA_W + CNT_W;

    typedef struct packed {
        logic [NBLK-1:0][SUM_W-1:0]  sum;
        logic [NBLK-1:0][LUMA_W-1:0] shd;
        logic [NBLK-1:0][LUMA_W-1:0] vis;
        logic [LUMA_W-1:0]           shd_max, shd_min, vis_max, vis_min;
        phase_e                      phase;
        logic [BLK_AW-1:0]           idx;
        logic                        issued;
        logic                        pending;
    } st_t;

    st_t st_d, st_q;
    logic              acc_en, last_pix, div_start, div_busy, div_done;
    logic [BLK_AW-1:0] blk_addr;
    logic [CNT_W-1:0]  blk_pixels;
    logic [LUMA_W-1:0] div_quo;

    exp_win_track #(.HW(HW), .VW(VW), .IMG_W(IMG_W), .IMG_H(IMG_H), .GRID_LG(GRID_LG)) u_track (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_strobe(line_strobe),
        .pix_valid(pix_valid), .h_start(win_h_start), .h_end(win_h_end),
        .v_start(win_v_start), .v_end(win_v_end), .h_en(win_h_en), .v_en(win_v_en),
        .acc_en(acc_en), .blk_addr(blk_addr), .last_pix(last_pix), .blk_pixels(blk_pixels)
    );

    exp_avg_div #(.SUM_W(SUM_W), .CNT_W(CNT_W), .Q_W(LUMA_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(st_q.sum[st_q.idx]),
        .divisor(blk_pixels), .busy(div_busy), .done(div_done), .quotient(div_quo)
    );

    always_comb begin
        st_d      = st_q;
        div_start = 1'b0;
        if (field_start) begin
            st_d.sum   = '0;
            st_d.phase = PH_IDLE;
            if (st_q.pending) begin
                st_d.vis     = st_q.shd;
                st_d.vis_max = st_q.shd_max;
                st_d.vis_min = st_q.shd_min;
                st_d.pending = 1'b0;
            end
        end else begin
            if (acc_en) begin
                st_d.sum[blk_addr] = st_q.sum[blk_addr] + SUM_W'(pix_luma);
            end
            if (st_q.phase == PH_DIV) begin
                if (!st_q.issued && !div_busy) begin
                    div_start   = 1'b1;
                    st_d.issued = 1'b1;
                end else if (div_done) begin
                    st_d.shd[st_q.idx] = div_quo;
                    if (st_q.idx == '0 || div_quo > st_q.shd_max) st_d.shd_max = div_quo;
                    if (st_q.idx == '0 || div_quo < st_q.shd_min) st_d.shd_min = div_quo;
                    if (st_q.idx == BLK_AW'(NBLK - 1)) begin
                        st_d.phase   = PH_IDLE;
                        st_d.pending = 1'b1;
                    end else begin
                        st_d.idx    = st_q.idx + BLK_AW'(1);
                        st_d.issued = 1'b0;
                    end
                end
            end
            if (last_pix) begin
                st_d.phase   = PH_DIV;
                st_d.idx     = '0;
                st_d.issued  = 1'b0;
                st_d.pending = 1'b0;
            end
        end

        if (!rd_addr[6])            rd_data = st_q.vis[rd_addr[5:0]];
        else if (rd_addr == ADDR_MAX) rd_data = st_q.vis_max;
        else if (rd_addr == ADDR_MIN) rd_data = st_q.vis_min;
        else                        rd_data = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [SUM_W-1:0]  chk_sum0;
    logic [LUMA_W-1:0] chk_vis_max, chk_vis_min;
    logic              chk_pending;
    assign chk_sum0    = st_q.sum[0];
    assign chk_vis_max = st_q.vis_max;
    assign chk_vis_min = st_q.vis_min;
    assign chk_pending = st_q.pending;
endmodule

// File: rtl/exp_stats_chk.sv
module exp_stats_chk #(
    parameter int LUMA_W = 8,
    parameter int SUM_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic              pix_valid,
    input logic              acc_en,
    input logic [6:0]        rd_addr,
    input logic [LUMA_W-1:0] rd_data,
    input logic [SUM_W-1:0]  sum0,
    input logic [LUMA_W-1:0] vis_max,
    input logic [LUMA_W-1:0] vis_min,
    input logic              pending
);
    // R6
    unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[6] && rd_addr != 7'h60 && rd_addr != 7'h61) |-> rd_data == '0);

    // R11
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> pix_valid);

    // R12
    sum_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> sum0 == '0);

    // R8
    vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(vis_max) && $stable(vis_min)));

    // R5
    max_ge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && pending) |=> vis_max >= vis_min);
endmodule

bind exp_stats_top exp_stats_chk #(.LUMA_W(LUMA_W), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .pix_valid(pix_valid),
    .acc_en(acc_en), .rd_addr(rd_addr), .rd_data(rd_data), .sum0(chk_sum0),
    .vis_max(chk_vis_max), .vis_min(chk_vis_min), .pending(chk_pending)
);

// File: tb/exp_stats_top_bench.sv
module exp_stats_top_bench;
    localparam int IMG_W = 64;
    localparam int IMG_H = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_start = 1'b0, line_strobe = 1'b0, pix_valid = 1'b0;
    logic [7:0] pix_luma = '0;
    logic [9:0] win_h_start = '0, win_h_end = '0;
    logic [8:0] win_v_start = '0, win_v_end = '0;
    logic       win_h_en = 1'b0, win_v_en = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    exp_stats_top #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_exp_stats_top (.*);

    typedef struct { int addr; int val; string tag; } item_t;
    item_t sb_q[$];
    int errors = 0, checks = 0;
    int exp_avg[64];
    int exp_max = 0, exp_min = 0;

    function automatic int lum(int x, int y, int seed);
        if (seed < 0) return (-seed) % 256;
        return (x * 7 + y * 13 + seed) % 256;
    endfunction

    // Expected results from R2, R3, R4, R5, R7, R9
    task automatic calc_exp(int hen, int hs, int he, int ven, int vs, int ve, int seed);
        int x0 = hen ? hs : 0;
        int x1 = hen ? he : IMG_W - 1;
        int y0 = ven ? vs : 0;
        int y1 = ven ? ve : IMG_H - 1;
        int bw = (x1 >= x0) ? (x1 - x0 + 1) / 8 : 0;
        int bh = (y1 >= y0) ? (y1 - y0 + 1) / 8 : 0;
        if (bw == 0 || bh == 0) return;
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) begin
                int s = 0;
                for (int x = x0 + c * bw; x < x0 + (c + 1) * bw; x++)
                    for (int y = y0 + r * bh; y < y0 + (r + 1) * bh; y++)
                        s += lum(x, y, seed);
                exp_avg[c * 8 + r] = s / (bw * bh);
            end
        end
        exp_max = 0; exp_min = 255;
        for (int i = 0; i < 64; i++) begin
            if (exp_avg[i] > exp_max) exp_max = exp_avg[i];
            if (exp_avg[i] < exp_min) exp_min = exp_avg[i];
        end
    endtask

    task automatic pulse_field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic run_field(int hen, int hs, int he, int ven, int vs, int ve, int seed, int tail);
        @(negedge clk);
        win_h_en = hen[0]; win_h_start = 10'(hs); win_h_end = 10'(he);
        win_v_en = ven[0]; win_v_start = 9'(vs);  win_v_end = 9'(ve);
        pulse_field();
        for (int y = 0; y < IMG_H; y++) begin
            if (y > 0) begin
                line_strobe = 1'b1; @(negedge clk); line_strobe = 1'b0;
            end
            for (int x = 0; x < IMG_W; x++) begin
                if (x % 5 == 4) begin          // R11: idle cycle with junk luma
                    pix_valid = 1'b0; pix_luma = 8'hFF; @(negedge clk);
                end
                pix_valid = 1'b1; pix_luma = 8'(lum(x, y, seed));
                @(negedge clk);
            end
            pix_valid = 1'b0;
        end
        repeat (tail) @(negedge clk);
    endtask

    task automatic push_all(string tag);
        for (int i = 0; i < 64; i++) sb_q.push_back('{i, exp_avg[i], tag});
        sb_q.push_back('{'h60, exp_max, {tag, " R5 max"}});
        sb_q.push_back('{'h61, exp_min, {tag, " R5 min"}});
    endtask

    // Monitor: pops expected items and compares against the read port (R10: same cycle)
    task automatic drain();
        while (sb_q.size() > 0) begin
            item_t it = sb_q.pop_front();
            @(negedge clk); rd_addr = 7'(it.addr);
            #1;
            checks++;
            if (rd_data !== 8'(it.val)) begin
                errors++;
                $display("FAIL %s addr=%02h actual=%0d expected=%0d", it.tag, it.addr, rd_data, it.val);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_avg[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        sb_q.push_back('{'h00, 0, "R1"}); sb_q.push_back('{'h3F, 0, "R1"});
        sb_q.push_back('{'h60, 0, "R1"}); sb_q.push_back('{'h61, 0, "R1"});
        drain();

        // Whole image, window inputs junk but disabled (R7), with idle strobes (R11)
        calc_exp(0, 40, 5, 0, 20, 2, 3);
        run_field(0, 40, 5, 0, 20, 2, 3, 2000);
        sb_q.push_back('{'h00, 0, "R8 hold before field start"}); drain();
        pulse_field(); push_all("R2 R3 R4 R7 R11"); drain();

        // Non-power-of-two window with leftovers (R2 R3 R9)
        sb_q.push_back('{'h12, exp_avg[18], "R8 hold"});
        calc_exp(1, 5, 50, 1, 3, 28, 100);
        run_field(1, 5, 50, 1, 3, 28, 100, 2000);
        drain();
        pulse_field(); push_all("R2 R3 R4 R10"); drain();

        // Horizontal window only (R7)
        calc_exp(1, 10, 33, 0, 7, 1, 200);
        run_field(1, 10, 33, 0, 7, 1, 200, 2000);
        pulse_field(); push_all("R7 R12"); drain();

        // Block width zero: no update (R9)
        calc_exp(1, 0, 5, 0, 0, 0, 50);
        run_field(1, 0, 5, 0, 0, 0, 50, 2000);
        pulse_field(); push_all("R9 no update"); drain();

        // Constant field: max equals min (R5), sums restart (R12)
        calc_exp(0, 0, 0, 0, 0, 0, -77);
        run_field(0, 0, 0, 0, 0, 0, -77, 2000);
        pulse_field(); push_all("R5 R12"); drain();

        // Field start during computation abandons it (R8)
        run_field(0, 0, 0, 0, 0, 0, 9, 50);
        pulse_field(); push_all("R8 abort"); drain();

        // Unused addresses (R6)
        sb_q.push_back('{'h40, 0, "R6"}); sb_q.push_back('{'h62, 0, "R6"});
        sb_q.push_back('{'h7F, 0, "R6"});
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule